// File: doc/BRIEF.md
# Pipelined Q1.15 Complex Multiplier with Operand Conjugation

This block multiplies two complex operands, X and Y, and returns their complex product. Each part of each operand, and each part of the result, is a 16-bit two's complement fraction (Q1.15). The four partial products are kept at full precision, then combined into the real part (difference) and the imaginary part (sum). The sums are optionally rounded, saturated and registered. One result leaves the pipeline every clock.

Each operand has its own load enable, so one side can stay fixed while the other streams. Either operand can be conjugated on entry without stalling the pipeline. The one product that cannot be represented, minus one times minus one, is clamped to the largest value below +1.0. A valid flag travels with the data. It marks the results that came from a cycle in which at least one operand was loaded.

Top module: `cmul_q15`

## Requirements
- R1: With rounding off, p_re = floor((XR·YR − XI'·YI') / 2^15) and p_im = floor((XR·YI' + XI'·YR) / 2^15). The products are exact, and XI' and YI' are the imaginary parts after optional conjugation. Equivalently, the full-precision sum is shifted right arithmetically by 15.
- R2: Operands, flags and loads presented before rising edge k affect p_re, p_im and p_valid from just after edge k+2. This is a fixed three-register latency, with a new result every cycle.
- R3: When x_load is low at an edge, the held X operand keeps its previous value. y_load does the same for Y. A held operand goes on being used for every following result.
- R4: conj_x and conj_y are captured at every edge, whatever the load enables. When conj_x is high, the imaginary part of X is negated before multiplication, and likewise for conj_y and Y. Negating 0x8000 gives 0x7FFF.
- R5: A partial product whose two factors are both 0x8000 is forced to 0x3FFF_FFFF in Q2.30, which is the largest value below +1.0. It is not +1.0.
- R6: round_en is captured at every edge and travels with its data. When it is high, 2^14 is added to each full-precision sum before the shift by 15.
- R7: A shifted result above 32767 gives 0x7FFF, and one below −32768 gives 0x8000.
- R8: p_valid equals (x_load OR y_load) as sampled three edges earlier.
- R9: While rst_n is low, p_re and p_im are zero and p_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_load | input | 1 | Load enable for the X operand register |
| y_load | input | 1 | Load enable for the Y operand register |
| x_re | input | 16 | Real part of X, Q1.15 |
| x_im | input | 16 | Imaginary part of X, Q1.15 |
| y_re | input | 16 | Real part of Y, Q1.15 |
| y_im | input | 16 | Imaginary part of Y, Q1.15 |
| conj_x | input | 1 | Negate the imaginary part of X |
| conj_y | input | 1 | Negate the imaginary part of Y |
| round_en | input | 1 | Add half an LSB before truncation |
| p_re | output | 16 | Real part of the product, Q1.15 |
| p_im | output | 16 | Imaginary part of the product, Q1.15 |
| p_valid | output | 1 | Result derives from a cycle with a load |

## Verification
A corrupted held operand shows up in every result after it, starting three cycles after the fault. Stall sequences that change the data pins while both loads are low expose it as a wrong p_re or p_im on the very first stalled result. A wrong partial product, trap or conjugation shows up two edges after the operand register. It is confined to the cycle that produced it, so the clamp and negation corner cases are driven directly and compared one result at a time. A misaligned shift or a missing round term moves p_re and p_im by one LSB or a factor of two at once. Small-magnitude and sign-boundary operands make this visible on the first affected vector.

// File: rtl/cmul_pkg.sv
package cmul_pkg;
    // Default width of every real or imaginary part
    localparam int unsigned CMUL_W = 16;

    // Which operand parts form each partial product
    typedef enum logic [1:0] {
        PP_RR = 2'd0,   // X real * Y real
        PP_II = 2'd1,   // X imag * Y imag
        PP_RI = 2'd2,   // X real * Y imag
        PP_IR = 2'd3    // X imag * Y real
    } pp_sel_e;
endpackage

// File: rtl/cmul_in_stage.sv
module cmul_in_stage #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                x_ld_i,
    input  logic                y_ld_i,
    input  logic signed [W-1:0] x_re_i,
    input  logic signed [W-1:0] x_im_i,
    input  logic signed [W-1:0] y_re_i,
    input  logic signed [W-1:0] y_im_i,
    input  logic                cj_x_i,
    input  logic                cj_y_i,
    input  logic                rnd_i,
    output logic signed [W-1:0] a_re_o,
    output logic signed [W-1:0] a_im_o,
    output logic signed [W-1:0] b_re_o,
    output logic signed [W-1:0] b_im_o,
    output logic                rnd_o,
    output logic                vld_o,
    output logic [2*W-1:0]      x_held_o,
    output logic [2*W-1:0]      y_held_o
);
    localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam int NOPS = 2;

    typedef struct packed {
        logic signed [W-1:0] xr;
        logic signed [W-1:0] xi;
        logic signed [W-1:0] yr;
        logic signed [W-1:0] yi;
        logic                cx;
        logic                cy;
        logic                rnd;
        logic                vld;
    } in_st_t;

    in_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (x_ld_i) begin
            st_d.xr = x_re_i;
            st_d.xi = x_im_i;
        end
        if (y_ld_i) begin
            st_d.yr = y_re_i;
            st_d.yi = y_im_i;
        end
        st_d.cx  = cj_x_i;
        st_d.cy  = cj_y_i;
        st_d.rnd = rnd_i;
        st_d.vld = x_ld_i | y_ld_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Conjugation applied on the way out of the operand registers
    logic signed [W-1:0] im_raw [NOPS];
    logic                cj_flag[NOPS];
    logic signed [W-1:0] im_cj  [NOPS];

    always_comb begin
        im_raw[0]  = st_q.xi;
        im_raw[1]  = st_q.yi;
        cj_flag[0] = st_q.cx;
        cj_flag[1] = st_q.cy;
    end

    for (genvar g = 0; g < NOPS; g++) begin : g_conj
        always_comb begin
            if (!cj_flag[g]) begin
                im_cj[g] = im_raw[g];
            end else if (im_raw[g] == MINV) begin
                im_cj[g] = MAXV;
            end else begin
                im_cj[g] = -im_raw[g];
            end
        end
    end

    assign a_re_o   = st_q.xr;
    assign a_im_o   = im_cj[0];
    assign b_re_o   = st_q.yr;
    assign b_im_o   = im_cj[1];
    assign rnd_o    = st_q.rnd;
    assign vld_o    = st_q.vld;
    assign x_held_o = {st_q.xr, st_q.xi};
    assign y_held_o = {st_q.yr, st_q.yi};
endmodule

// File: rtl/cmul_prod_stage.sv
module cmul_prod_stage
    import cmul_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic signed [W-1:0]    a_re_i,
    input  logic signed [W-1:0]    a_im_i,
    input  logic signed [W-1:0]    b_re_i,
    input  logic signed [W-1:0]    b_im_i,
    input  logic                   rnd_i,
    input  logic                   vld_i,
    output logic [3:0][2*W-1:0]    pp_o,
    output logic                   rnd_o,
    output logic                   vld_o
);
    localparam int PW = 2 * W;
    localparam int NPP = 4;
    localparam logic signed [W-1:0]  MINV  = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [PW-1:0] TRAPV = {2'b00, {(PW-2){1'b1}}};

    typedef struct packed {
        logic [3:0][PW-1:0] pp;
        logic               rnd;
        logic               vld;
    } pr_st_t;

    pr_st_t st_d, st_q;

    logic signed [PW-1:0] pp_c[NPP];

    for (genvar k = 0; k < NPP; k++) begin : g_pp
        localparam pp_sel_e SEL  = pp_sel_e'(k);
        localparam bit      A_IM = (SEL == PP_II) || (SEL == PP_IR);
        localparam bit      B_IM = (SEL == PP_II) || (SEL == PP_RI);
        logic signed [W-1:0] fa, fb;
        logic                trap;
        assign fa   = A_IM ? a_im_i : a_re_i;
        assign fb   = B_IM ? b_im_i : b_re_i;
        assign trap = (fa == MINV) && (fb == MINV);
        assign pp_c[k] = trap ? TRAPV : fa * fb;
    end

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NPP; k++) begin
            st_d.pp[k] = pp_c[k];
        end
        st_d.rnd = rnd_i;
        st_d.vld = vld_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pp_o  = st_q.pp;
    assign rnd_o = st_q.rnd;
    assign vld_o = st_q.vld;
endmodule

// File: rtl/cmul_sum_stage.sv
module cmul_sum_stage
    import cmul_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0][2*W-1:0] pp_i,
    input  logic                rnd_i,
    input  logic                vld_i,
    output logic signed [W-1:0] re_o,
    output logic signed [W-1:0] im_o,
    output logic                vld_o
);
    localparam int PW = 2 * W;
    localparam int SW = PW + 1;
    localparam int NLANE = 2;
    localparam logic signed [W-1:0]  MINV = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [W-1:0]  MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [SW-1:0] HALF = {{(SW-W+1){1'b0}}, 1'b1, {(W-2){1'b0}}};
    localparam logic signed [SW-1:0] HI   = {{(SW-W){1'b0}}, MAXV};
    localparam logic signed [SW-1:0] LO   = {{(SW-W){1'b1}}, MINV};

    typedef struct packed {
        logic signed [W-1:0] re;
        logic signed [W-1:0] im;
        logic                vld;
    } out_st_t;

    out_st_t st_d, st_q;

    logic signed [SW-1:0] pp_x[4];
    logic signed [W-1:0]  lane_res[NLANE];

    always_comb begin
        for (int k = 0; k < 4; k++) begin
            pp_x[k] = $signed({pp_i[k][PW-1], pp_i[k]});
        end
    end

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic signed [SW-1:0] acc, rnd_acc, shf;
        if (g == 0) begin : g_real
            assign acc = pp_x[PP_RR] - pp_x[PP_II];
        end else begin : g_imag
            assign acc = pp_x[PP_RI] + pp_x[PP_IR];
        end
        assign rnd_acc = rnd_i ? (acc + HALF) : acc;
        assign shf     = rnd_acc >>> (W - 1);
        always_comb begin
            if (shf > HI) begin
                lane_res[g] = MAXV;
            end else if (shf < LO) begin
                lane_res[g] = MINV;
            end else begin
                lane_res[g] = shf[W-1:0];
            end
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.re  = lane_res[0];
        st_d.im  = lane_res[1];
        st_d.vld = vld_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign re_o  = st_q.re;
    assign im_o  = st_q.im;
    assign vld_o = st_q.vld;
endmodule

// File: rtl/cmul_q15.sv
module cmul_q15 #(
    parameter int W = cmul_pkg::CMUL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                x_load,
    input  logic                y_load,
    input  logic signed [W-1:0] x_re,
    input  logic signed [W-1:0] x_im,
    input  logic signed [W-1:0] y_re,
    input  logic signed [W-1:0] y_im,
    input  logic                conj_x,
    input  logic                conj_y,
    input  logic                round_en,
    output logic signed [W-1:0] p_re,
    output logic signed [W-1:0] p_im,
    output logic                p_valid
);
    localparam int PW = 2 * W;

    logic signed [W-1:0] a_re, a_im, b_re, b_im;
    logic                rnd_s1, vld_s1, rnd_s2, vld_s2;
    logic [PW-1:0]       x_held, y_held;
    logic [3:0][PW-1:0]  pp;

    cmul_in_stage #(.W(W)) u_in (
        .clk      (clk),
        .rst_n    (rst_n),
        .x_ld_i   (x_load),
        .y_ld_i   (y_load),
        .x_re_i   (x_re),
        .x_im_i   (x_im),
        .y_re_i   (y_re),
        .y_im_i   (y_im),
        .cj_x_i   (conj_x),
        .cj_y_i   (conj_y),
        .rnd_i    (round_en),
        .a_re_o   (a_re),
        .a_im_o   (a_im),
        .b_re_o   (b_re),
        .b_im_o   (b_im),
        .rnd_o    (rnd_s1),
        .vld_o    (vld_s1),
        .x_held_o (x_held),
        .y_held_o (y_held)
    );

    cmul_prod_stage #(.W(W)) u_prod (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_re_i (a_re),
        .a_im_i (a_im),
        .b_re_i (b_re),
        .b_im_i (b_im),
        .rnd_i  (rnd_s1),
        .vld_i  (vld_s1),
        .pp_o   (pp),
        .rnd_o  (rnd_s2),
        .vld_o  (vld_s2)
    );

    cmul_sum_stage #(.W(W)) u_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .pp_i  (pp),
        .rnd_i (rnd_s2),
        .vld_i (vld_s2),
        .re_o  (p_re),
        .im_o  (p_im),
        .vld_o (p_valid)
    );
endmodule

// File: rtl/cmul_q15_chk.sv
module cmul_q15_chk #(
    parameter int W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                x_load,
    input logic                y_load,
    input logic [2*W-1:0]      x_held,
    input logic [2*W-1:0]      y_held,
    input logic [W-1:0]        a_re,
    input logic [W-1:0]        b_re,
    input logic [3:0][2*W-1:0] pp,
    input logic [W-1:0]        p_re,
    input logic [W-1:0]        p_im,
    input logic                p_valid
);
    localparam logic [W-1:0]   MINV  = {1'b1, {(W-1){1'b0}}};
    localparam logic [2*W-1:0] TRAPV = {2'b00, {(2*W-2){1'b1}}};

    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    // R3: X operand register holds when its enable is low
    assert_hold_x_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !x_load |=> x_held == $past(x_held));

    // R3: Y operand register holds when its enable is low
    assert_hold_y_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !y_load |=> y_held == $past(y_held));

    // R5: minus one squared is clamped in the partial product
    assert_trap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (a_re == MINV && b_re == MINV) |=> pp[0] == TRAPV);

    // R8: the valid flag follows the loads by three edges
    assert_valid_lat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> p_valid == $past(x_load || y_load, 3));

    // R9: outputs are cleared while reset is held
    always @(negedge clk) begin
        if (!rst_n) begin
            assert_reset_R9: assert (p_re == '0 && p_im == '0 && !p_valid)
                else $error("reset state violated");
        end
    end
endmodule

bind cmul_q15 cmul_q15_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .x_load  (x_load),
    .y_load  (y_load),
    .x_held  (x_held),
    .y_held  (y_held),
    .a_re    (a_re),
    .b_re    (b_re),
    .pp      (pp),
    .p_re    (p_re),
    .p_im    (p_im),
    .p_valid (p_valid)
);

// File: tb/cmul_q15_bench.sv
module cmul_q15_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic x_load = 1'b0, y_load = 1'b0;
    logic signed [15:0] x_re = '0, x_im = '0, y_re = '0, y_im = '0;
    logic conj_x = 1'b0, conj_y = 1'b0, round_en = 1'b0;
    logic signed [15:0] p_re, p_im;
    logic p_valid;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // shadow of the held operands
    logic signed [15:0] sx_re = '0, sx_im = '0, sy_re = '0, sy_im = '0;
    // expected results, index 0 newest
    logic signed [15:0] h_re[3];
    logic signed [15:0] h_im[3];
    logic               h_v[3];
    string              h_tag[3];

    always #2 clk = ~clk;

    cmul_q15 u_cmul_q15 (
        .clk(clk), .rst_n(rst_n), .x_load(x_load), .y_load(y_load),
        .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im),
        .conj_x(conj_x), .conj_y(conj_y), .round_en(round_en),
        .p_re(p_re), .p_im(p_im), .p_valid(p_valid)
    );

    function automatic longint neg_sat(input longint v);
        return (v == -32768) ? 32767 : -v;
    endfunction

    function automatic longint pmul(input longint a, input longint b);
        return (a == -32768 && b == -32768) ? 64'sd1073741823 : a * b;
    endfunction

    function automatic logic signed [15:0] finish_lane(input longint s, input bit rnd);
        longint t;
        t = rnd ? s + 16384 : s;
        t = t >>> 15;
        if (t > 32767) return 16'sh7fff;
        if (t < -32768) return 16'sh8000;
        return 16'(t);
    endfunction

    task automatic do_check(input bit ok, input string tag, input string act, input string exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    task automatic step(input bit xl, input bit yl,
                        input logic [15:0] xr, input logic [15:0] xi,
                        input logic [15:0] yr, input logic [15:0] yi,
                        input bit cx, input bit cy, input bit rnd, input string tag);
        longint ar, ai, br, bi;
        @(negedge clk);
        do_check(p_re === h_re[2] && p_im === h_im[2] && p_valid === h_v[2],
                 {h_tag[2], " R2 R8"},
                 $sformatf("%h/%h v%b", p_re, p_im, p_valid),
                 $sformatf("%h/%h v%b", h_re[2], h_im[2], h_v[2]));
        for (int i = 2; i > 0; i--) begin
            h_re[i] = h_re[i-1]; h_im[i] = h_im[i-1];
            h_v[i] = h_v[i-1]; h_tag[i] = h_tag[i-1];
        end
        x_load = xl; y_load = yl; x_re = xr; x_im = xi; y_re = yr; y_im = yi;
        conj_x = cx; conj_y = cy; round_en = rnd;
        if (xl) begin sx_re = xr; sx_im = xi; end
        if (yl) begin sy_re = yr; sy_im = yi; end
        ar = longint'(sx_re); ai = longint'(sx_im);
        br = longint'(sy_re); bi = longint'(sy_im);
        if (cx) ai = neg_sat(ai);
        if (cy) bi = neg_sat(bi);
        h_re[0]  = finish_lane(pmul(ar, br) - pmul(ai, bi), rnd);
        h_im[0]  = finish_lane(pmul(ar, bi) + pmul(ai, br), rnd);
        h_v[0]   = xl | yl;
        h_tag[0] = tag;
    endtask

    function automatic logic [15:0] pick();
        int unsigned r;
        r = $urandom % 8;
        if (r == 0) return 16'h8000;
        if (r == 1) return 16'h7fff;
        return 16'($urandom);
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog expired actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        for (int i = 0; i < 3; i++) begin
            h_re[i] = '0; h_im[i] = '0; h_v[i] = 1'b0; h_tag[i] = "R9";
        end
        // R9: reset state, with inputs toggling
        repeat (2) @(negedge clk);
        x_load = 1'b1; y_load = 1'b1; x_re = 16'h4000; y_re = 16'h4000;
        @(negedge clk);
        do_check(p_re === 16'h0 && p_im === 16'h0 && p_valid === 1'b0, "R9",
                 $sformatf("%h/%h v%b", p_re, p_im, p_valid), "0000/0000 v0");
        x_load = 1'b0; y_load = 1'b0; x_re = '0; y_re = '0;
        @(negedge clk);
        rst_n = 1'b1;

        // R5: minus one squared, plain and rounded
        step(1, 1, 16'h8000, 16'h0000, 16'h8000, 16'h0000, 0, 0, 0, "R5");
        step(1, 1, 16'h8000, 16'h0000, 16'h8000, 16'h0000, 0, 0, 1, "R5 R6");
        step(1, 1, 16'h0000, 16'h8000, 16'h0000, 16'h8000, 0, 0, 0, "R5");
        // R4: all four conjugation combinations
        for (int c = 0; c < 4; c++)
            step(1, 1, 16'h4000, 16'h2000, 16'h1000, 16'h6000, c[0], c[1], 0, "R4");
        // R4: conjugating 0x8000 gives 0x7FFF
        step(1, 1, 16'h4000, 16'h8000, 16'h4000, 16'h8000, 1, 0, 0, "R4");
        step(1, 1, 16'h4000, 16'h8000, 16'h4000, 16'h8000, 0, 1, 0, "R4");
        // R7: positive and negative sum saturation
        step(1, 1, 16'h8000, 16'h8000, 16'h8000, 16'h7fff, 0, 0, 0, "R7");
        step(1, 1, 16'h8000, 16'h7fff, 16'h7fff, 16'h7fff, 0, 0, 0, "R7");
        // R6 and R1: half-LSB rounding and floor truncation
        step(1, 1, 16'h0001, 16'h0000, 16'h4000, 16'h0000, 0, 0, 0, "R1");
        step(1, 1, 16'h0001, 16'h0000, 16'h4000, 16'h0000, 0, 0, 1, "R6");
        step(1, 1, 16'hffff, 16'h0000, 16'h4000, 16'h0000, 0, 0, 0, "R1");
        step(1, 1, 16'hffff, 16'h0000, 16'h4000, 16'h0000, 0, 0, 1, "R6");
        // R3: stalls on each enable while data pins change
        step(1, 1, 16'h3000, 16'hd000, 16'h2000, 16'h1000, 0, 0, 0, "R3");
        step(0, 0, 16'h7fff, 16'h7fff, 16'h7fff, 16'h7fff, 0, 0, 0, "R3");
        step(0, 1, 16'h8000, 16'h8000, 16'h0800, 16'hf800, 0, 0, 0, "R3");
        step(1, 0, 16'h1234, 16'h4321, 16'h8000, 16'h8000, 0, 0, 0, "R3");
        step(0, 0, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1, 1, 1, "R3 R4");
        // random mix
        for (int n = 0; n < 3000; n++) begin
            step(($urandom % 4) != 0, ($urandom % 4) != 0,
                 pick(), pick(), pick(), pick(),
                 1'($urandom), 1'($urandom), 1'($urandom), "R1");
        end
        for (int n = 0; n < 3; n++)
            step(0, 0, 16'h0, 16'h0, 16'h0, 16'h0, 0, 0, 0, "R8");
        @(negedge clk);
        do_check(p_valid === 1'b0, "R8", $sformatf("v%b", p_valid), "v0");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule